// File: doc/BRIEF.md
# ROM Bank Selector with Interrupt Vector Override

This block holds the ROM bank number of an 8-bit 6502-family system and drives the bank select lines from it. The CPU, or any other bus master, changes the bank by writing the zero-page byte at `$0001`. The block also produces two chip selects for the `$C000`-`$FFFF` window. The on-board ROM select covers banks 0 to 31. The cartridge select covers every higher bank, so an expansion cartridge can supply those banks without contention.

When the CPU signals that it is pulling an interrupt vector, the bank on the outputs becomes zero in that same cycle and stays zero under a held override flag. The stored bank is not touched. The handler releases the override with a trigger: either an opcode fetch of `0x42` (used as a no-operation) or a write to a dedicated I/O address. After the trigger, a parameterised number of later opcode fetches must pass before the stored bank returns. With the default of one, the return-from-interrupt opcode is still fetched under bank zero. The bus-enable input is accepted on the port and has no effect: the bank lines are always driven.

There is no data stream through this block, so every pin is a plain control or status signal and no valid/ready handshake applies.

Top module: `rom_bank_ctl`

## Requirements
- R1: A cycle with `rw_i`=0 and `addr_i`=`$0001` loads `data_i` into the stored bank at the clock edge. Reads of `$0001` and writes to any other address leave the stored bank unchanged.
- R2: Synchronous reset (`rst`=1 at a clock edge) clears the stored bank to 0 and clears the override and the restore countdown.
- R3: `rom_cs_o` is 1 exactly when `addr_i` >= `$C000` and the bank on `bank_o` is below 32.
- R4: `cart_cs_o` is 1 exactly when `addr_i` >= `$C000` and the bank on `bank_o` is 32 or more. The two selects are never both 1.
- R5: `bus_en_i` has no effect. The bank outputs are neither released nor changed by it, and writes to `$0001` still load while it is low.
- R6: While `vec_pull_i`=1, `bank_o` is 0 in the same cycle. From the next cycle the override flag holds `bank_o` at 0 until the release sequence completes.
- R7: An opcode fetch (`sync_i`=1, `rw_i`=1) with `data_i`=`0x42` is a release trigger. Opcode fetches before a trigger do not release. With the default count of 1, the stored bank appears on `bank_o` in the cycle after the first opcode fetch that follows the trigger.
- R8: A write (`rw_i`=0) to the trigger address `$9F60` is also a release trigger, with the same countdown as R7.
- R9: A vector pull during the countdown cancels it and holds the override again. Later opcode fetches do not release it until a new trigger arrives.
- R10: Writes to `$0001` while the override is active update the stored bank without changing `bank_o`. The newly written value is the one that appears after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus (write data or fetched opcode) |
| rw_i | input | 1 | 1 = read, 0 = write |
| sync_i | input | 1 | High during an opcode fetch |
| vec_pull_i | input | 1 | High while an interrupt vector is fetched |
| bus_en_i | input | 1 | CPU bus enable; has no effect on this block |
| bank_o | output | 8 | Effective ROM bank select lines |
| rom_cs_o | output | 1 | On-board ROM select, active high |
| cart_cs_o | output | 1 | Cartridge ROM select, active high |

## Verification
The hardest state to reach is a vector pull that arrives in the middle of a restore countdown. From the ports this takes an override, then a trigger, then a second pull before the next opcode fetch. Only extra opcode fetches that leave the bank at zero show that the countdown was dropped. The stimulus builds exactly that sequence, then issues a fresh trigger and fetch to prove the override can still be released. A bank written during the override is used to make the restored value distinguishable from the value held before the interrupt.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  typedef enum logic [1:0] {
    OVR_IDLE  = 2'd0,
    OVR_HELD  = 2'd1,
    OVR_COUNT = 2'd2
  } ovr_state_e;
endpackage

// File: rtl/rbank_reg.sv
module rbank_reg #(
  parameter int                ADDR_W    = 16,
  parameter int                BANK_W    = 8,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] data_i,
  input  logic              rw_i,
  output logic [BANK_W-1:0] bank_q
);
  logic load;
  assign load = !rw_i && (addr_i == BANK_ADDR);

  always_ff @(posedge clk) begin
    if (rst)       bank_q <= '0;
    else if (load) bank_q <= data_i;
  end
endmodule

// File: rtl/rbank_trig.sv
module rbank_trig #(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR   = 'h9F60,
  parameter logic [DATA_W-1:0] TRIG_OPCODE = 'h42
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rw_i,
  input  logic              sync_i,
  output logic              trigger_o,
  output logic              fetch_o
);
  logic op_hit, io_hit;

  // opcode fetch is a read with SYNC high
  assign fetch_o   = sync_i && rw_i;
  assign op_hit    = fetch_o && (data_i == TRIG_OPCODE);
  assign io_hit    = !rw_i && (addr_i == TRIG_ADDR);
  assign trigger_o = op_hit || io_hit;
endmodule

// File: rtl/rbank_override.sv
module rbank_override
  import rbank_pkg::*;
#(
  parameter int RESTORE_CNT = 1,
  localparam int CNT_W = (RESTORE_CNT < 2) ? 1 : $clog2(RESTORE_CNT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic vec_pull_i,
  input  logic trigger_i,
  input  logic fetch_i,
  output logic ovr_o
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESTORE_CNT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  ovr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      OVR_IDLE: begin
        if (vec_pull_i) state_d = OVR_HELD;
      end
      OVR_HELD: begin
        if (!vec_pull_i && trigger_i) begin
          state_d = OVR_COUNT;
          cnt_d   = CNT_LOAD;
        end
      end
      OVR_COUNT: begin
        if (vec_pull_i) begin
          state_d = OVR_HELD;
          cnt_d   = '0;
        end else if (trigger_i) begin
          cnt_d = CNT_LOAD;
        end else if (fetch_i) begin
          if (cnt_q == CNT_ONE) begin
            state_d = OVR_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
      end
      default: begin
        state_d = OVR_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= OVR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ovr_o = (state_q != OVR_IDLE);
endmodule

// File: rtl/rbank_decode.sv
module rbank_decode #(
  parameter int                ADDR_W        = 16,
  parameter int                BANK_W        = 8,
  parameter int                ONBOARD_BANKS = 32,
  parameter logic [ADDR_W-1:0] ROM_WIN_LO    = 'hC000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_q,
  input  logic              force_zero,
  output logic [BANK_W-1:0] bank_o,
  output logic              rom_cs_o,
  output logic              cart_cs_o
);
  logic in_win, onboard;

  assign bank_o    = force_zero ? '0 : bank_q;
  assign in_win    = (addr_i >= ROM_WIN_LO);
  assign onboard   = (int'(bank_o) < ONBOARD_BANKS);
  assign rom_cs_o  = in_win && onboard;
  assign cart_cs_o = in_win && !onboard;
endmodule

// File: rtl/rom_bank_ctl.sv
module rom_bank_ctl #(
  parameter int                ADDR_W        = 16,
  parameter int                DATA_W        = 8,
  parameter int                ONBOARD_BANKS = 32,
  parameter int                RESTORE_CNT   = 1,
  parameter logic [ADDR_W-1:0] BANK_ADDR     = 'h0001,
  parameter logic [ADDR_W-1:0] TRIG_ADDR     = 'h9F60,
  parameter logic [ADDR_W-1:0] ROM_WIN_LO    = 'hC000,
  parameter logic [DATA_W-1:0] TRIG_OPCODE   = 'h42
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rw_i,
  input  logic              sync_i,
  input  logic              vec_pull_i,
  input  logic              bus_en_i,
  output logic [DATA_W-1:0] bank_o,
  output logic              rom_cs_o,
  output logic              cart_cs_o
);
  logic [DATA_W-1:0] bank_q;
  logic              trigger, fetch, ovr_q, force_zero;
  logic              unused_bus_en;

  // bank lines stay driven whatever the bus-enable pin does
  assign unused_bus_en = bus_en_i;

  rbank_reg #(.ADDR_W(ADDR_W), .BANK_W(DATA_W), .BANK_ADDR(BANK_ADDR)) reg_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .data_i(data_i), .rw_i(rw_i),
    .bank_q(bank_q)
  );

  rbank_trig #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_ADDR(TRIG_ADDR),
               .TRIG_OPCODE(TRIG_OPCODE)) trig_i (
    .addr_i(addr_i), .data_i(data_i), .rw_i(rw_i), .sync_i(sync_i),
    .trigger_o(trigger), .fetch_o(fetch)
  );

  rbank_override #(.RESTORE_CNT(RESTORE_CNT)) ovr_i (
    .clk(clk), .rst(rst), .vec_pull_i(vec_pull_i), .trigger_i(trigger),
    .fetch_i(fetch), .ovr_o(ovr_q)
  );

  // vector pull forces bank zero already in the fetch cycle
  assign force_zero = ovr_q || vec_pull_i;

  rbank_decode #(.ADDR_W(ADDR_W), .BANK_W(DATA_W), .ONBOARD_BANKS(ONBOARD_BANKS),
                 .ROM_WIN_LO(ROM_WIN_LO)) dec_i (
    .addr_i(addr_i), .bank_q(bank_q), .force_zero(force_zero),
    .bank_o(bank_o), .rom_cs_o(rom_cs_o), .cart_cs_o(cart_cs_o)
  );
endmodule

// File: rtl/rom_bank_ctl_chk.sv
module rom_bank_ctl_chk #(
  parameter int                ADDR_W        = 16,
  parameter int                DATA_W        = 8,
  parameter int                ONBOARD_BANKS = 32,
  parameter logic [ADDR_W-1:0] BANK_ADDR     = 'h0001,
  parameter logic [ADDR_W-1:0] ROM_WIN_LO    = 'hC000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              rw_i,
  input logic              vec_pull_i,
  input logic [DATA_W-1:0] bank_q,
  input logic              ovr_q,
  input logic [DATA_W-1:0] bank_o,
  input logic              rom_cs_o,
  input logic              cart_cs_o
);
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!rw_i && addr_i == BANK_ADDR) |=> (bank_q == $past(data_i))); // R1
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(!rw_i && addr_i == BANK_ADDR) |=> $stable(bank_q)); // R1
  AST_ROM_RANGE: assert property (@(posedge clk) disable iff (rst)
    rom_cs_o |-> (int'(bank_o) < ONBOARD_BANKS && addr_i >= ROM_WIN_LO)); // R3
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs_o, cart_cs_o})); // R4
  AST_CART_RANGE: assert property (@(posedge clk) disable iff (rst)
    cart_cs_o |-> (int'(bank_o) >= ONBOARD_BANKS && addr_i >= ROM_WIN_LO)); // R4
  AST_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    vec_pull_i |-> (bank_o == '0)); // R6
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    vec_pull_i |=> ovr_q); // R6
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    (!ovr_q && !vec_pull_i) |-> (bank_o == bank_q)); // R10
endmodule

bind rom_bank_ctl rom_bank_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ONBOARD_BANKS(ONBOARD_BANKS),
  .BANK_ADDR(BANK_ADDR), .ROM_WIN_LO(ROM_WIN_LO)
) chk_i (
  .clk(clk), .rst(rst), .addr_i(addr_i), .data_i(data_i), .rw_i(rw_i),
  .vec_pull_i(vec_pull_i), .bank_q(bank_q), .ovr_q(ovr_q), .bank_o(bank_o),
  .rom_cs_o(rom_cs_o), .cart_cs_o(cart_cs_o)
);

// File: tb/rom_bank_ctl_tb_top.sv
`timescale 1ns/1ps
module rom_bank_ctl_tb_top;
  typedef struct {
    logic [7:0] bank;
    logic       rom;
    logic       cart;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic        rw = 1'b1;
  logic        sync = 1'b0;
  logic        vp = 1'b0;
  logic        be = 1'b1;
  logic [7:0]  bank;
  logic        rom_cs, cart_cs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb_q[$];

  // bench reference state
  logic [7:0] m_bank = 8'h00;
  bit         m_ovr = 1'b0;
  bit         m_cnt_on = 1'b0;

  always #2.5 clk = ~clk;

  rom_bank_ctl dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .data_i(data), .rw_i(rw),
    .sync_i(sync), .vec_pull_i(vp), .bus_en_i(be),
    .bank_o(bank), .rom_cs_o(rom_cs), .cart_cs_o(cart_cs)
  );

  // driver: applies one bus cycle, queues expected outputs, advances the model
  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input bit r,
                     input bit s, input bit v, input bit b, input string tag);
    exp_t e;
    logic [7:0] eff;
    bit trig, fetch;
    @(negedge clk);
    addr = a; data = d; rw = r; sync = s; vp = v; be = b;
    if (rst) begin
      m_bank = 8'h00; m_ovr = 1'b0; m_cnt_on = 1'b0;
    end else begin
      eff    = (m_ovr || v) ? 8'h00 : m_bank;
      e.bank = eff;
      e.rom  = (a >= 16'hC000) && (eff < 8'd32);
      e.cart = (a >= 16'hC000) && (eff >= 8'd32);
      e.tag  = tag;
      sb_q.push_back(e);
      fetch = s && r;
      trig  = (fetch && d == 8'h42) || (!r && a == 16'h9F60);
      if (!r && a == 16'h0001) m_bank = d;
      if (v) begin
        m_ovr = 1'b1; m_cnt_on = 1'b0;
      end else if (m_ovr && trig) begin
        m_cnt_on = 1'b1;
      end else if (m_cnt_on && fetch) begin
        m_ovr = 1'b0; m_cnt_on = 1'b0;
      end
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    cyc(a, 8'hEA, 1'b1, 1'b0, 1'b0, 1'b1, tag);
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    cyc(a, d, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask
  task automatic fetch_op(input logic [7:0] op, input string tag);
    cyc(16'hC100, op, 1'b1, 1'b1, 1'b0, 1'b1, tag);
  endtask

  // monitor: compares each queued item in the middle of its cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (bank !== e.bank || rom_cs !== e.rom || cart_cs !== e.cart) begin
          fails++;
          $display("FAIL %s: bank=%0h rom=%0b cart=%0b expected bank=%0h rom=%0b cart=%0b",
                   e.tag, bank, rom_cs, cart_cs, e.bank, e.rom, e.cart);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    wr(16'h0001, 8'h55, "reset");
    rd(16'hC000, "reset");
    @(negedge clk); rst = 1'b0;
    // R2: register cleared despite a write while in reset
    rd(16'hFFFC, "R2 reset bank zero, rom selected");
    // R1
    wr(16'h0001, 8'h05, "R1 write bank");
    rd(16'hE000, "R1 bank 5 visible");
    wr(16'h0002, 8'h77, "R1 other address ignored");
    cyc(16'h0001, 8'h99, 1'b1, 1'b0, 1'b0, 1'b1, "R1 read of bank addr ignored");
    rd(16'hE000, "R1 bank still 5");
    // R3 / R4 boundaries
    wr(16'h0001, 8'd31, "R3 write bank 31");
    rd(16'hC000, "R3 bank 31 on-board at window base");
    rd(16'hBFFF, "R3 below window no select");
    wr(16'h0001, 8'd32, "R4 write bank 32");
    rd(16'hC000, "R4 bank 32 cartridge");
    rd(16'hBFFF, "R4 below window no cartridge");
    wr(16'h0001, 8'hFF, "R4 write bank 255");
    rd(16'hFFFF, "R4 bank 255 cartridge");
    // R5: bus enable low changes nothing
    cyc(16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R5 bus enable low bank kept");
    cyc(16'h0001, 8'd40, 1'b0, 1'b0, 1'b0, 1'b0, "R5 write while bus enable low");
    cyc(16'hC000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R5 bank 40 loaded");
    // R6: vector pull
    cyc(16'hFFFE, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R6 vector pull forces zero");
    cyc(16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R6 vector pull second byte");
    rd(16'hC200, "R6 override held");
    // R10: write during override
    wr(16'h0001, 8'h0A, "R10 write during override");
    rd(16'hC200, "R10 output still zero");
    // R7: non-trigger fetches do not release
    fetch_op(8'hA9, "R7 fetch before trigger");
    fetch_op(8'hEA, "R7 second fetch before trigger");
    rd(16'hC200, "R7 still zero");
    fetch_op(8'h42, "R7 trigger opcode fetch");
    rd(16'hC201, "R7 countdown running");
    fetch_op(8'h40, "R7 return opcode under bank zero");
    rd(16'hC000, "R10 stored value restored after R7");
    // R8: I/O trigger
    cyc(16'hFFFA, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R8 vector pull");
    rd(16'hC300, "R8 override held");
    wr(16'h9F60, 8'h00, "R8 trigger write");
    rd(16'hC300, "R8 countdown running");
    fetch_op(8'h40, "R8 release fetch");
    rd(16'hC000, "R8 bank 10 restored");
    // R9: vector pull during countdown cancels it
    wr(16'h0001, 8'd50, "R9 set bank 50");
    cyc(16'hFFFE, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R9 first vector pull");
    fetch_op(8'h42, "R9 trigger");
    cyc(16'hFFFE, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R9 second pull in countdown");
    fetch_op(8'h40, "R9 fetch after cancel");
    fetch_op(8'hEA, "R9 second fetch after cancel");
    rd(16'hC000, "R9 still zero");
    fetch_op(8'h42, "R9 new trigger");
    fetch_op(8'h40, "R9 release fetch");
    rd(16'hC000, "R9 bank 50 cartridge again");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule